// File: doc/BRIEF.md
# Debug Command Unit for a JTAG Streaming Bridge

This block serves the host side of a JTAG-to-streaming bridge. It runs one small debug command at a time, so that a host can probe the system around it. A command is a 3-bit code. It is presented with a one-cycle start strobe and, for loopback, a data byte. The block answers with one result byte and a one-cycle done strobe. The commands are: echo a byte, take a single sample of the system clock level, take a single sample of the active-low system reset level, report whether the system clock is toggling, and pulse a reset request to the external system for a long, parameterised time.

All control logic runs on the host clock. Levels taken from the system domain pass through a two-flop synchronizer. The clock-activity flag sits in the system clock domain. It is set by any rising edge of that clock and is cleared from the host side when a sense command begins. The command input has no ready signal. A start is taken only while `busy` is low, and any start seen while `busy` is high is dropped. The response cannot be held back. It is valid in the cycle that `done` is high and stays unchanged until the next start that is taken.

Top module: `dbg_cmd_unit`

## Requirements
- R1: After host reset, `busy`, `done` and `reset_request` are low and `result` is 8'h00.
- R2: Code 3'd0 (loopback) returns the `cmd_data` byte present at the accepted start, unchanged.
- R3: Code 3'd1 returns 8'h00. It raises `reset_request` from the cycle after the accepting edge and holds it high for exactly HOLD_CYCLES host cycles.
- R4: A code 3'd1 accepted while `reset_request` is still high restarts the count. The request stays high without a gap until HOLD_CYCLES cycles after that later start.
- R5: Code 3'd2 returns {7'b0, L}, where L is the synchronized level of `sys_clk`. This assumes `sys_clk` has been steady for at least three host cycles.
- R6: Code 3'd3 returns {7'b0, L}, where L is the synchronized level of `sys_rst_n`.
- R7: Code 3'd4 clears the activity flag, waits SENSE_WAIT host cycles and then returns 8'h01 if `sys_clk` rose after the clear, or 8'h00 if it did not. Any clock activity before the command does not count.
- R8: Codes 3'd5 to 3'd7 return 8'hFF with `done`.
- R9: `busy` is high from the cycle after the accepting edge until `done`. It is low in the `done` cycle. A start seen while `busy` is high is ignored and produces no `done`.
- R10: `done` lasts one host cycle. `result` does not change from `done` until the next accepted start completes.
- R11: For every code except 3'd4, `done` is high in the second cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host (JTAG side) clock |
| hrst_n | input | 1 | Host reset, active low, asynchronous |
| sys_clk | input | 1 | System clock being checked |
| sys_rst_n | input | 1 | System reset level being checked, active low |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Command code |
| cmd_data | input | 8 | Data byte for loopback |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 8 | Result byte |
| reset_request | output | 1 | Reset request to the external system |

## Verification
The hardest case is a sense command that must report 0 after the system clock has just been running. That outcome depends on the host-side clear reaching the other domain before any later edge. The bench owns a system clock generator that it can stop at either level. It runs the clock, stops it, and then issues the sense command. It also drops extra start strobes into the long sense wait, and it restarts the reset hold partway through, measuring the request length against the recorded acceptance cycles.

// File: rtl/dbg_cmd_pkg.sv
`timescale 1ns/1ps
package dbg_cmd_pkg;
  typedef enum logic [2:0] {
    OP_LOOP   = 3'd0,
    OP_RSTSYS = 3'd1,
    OP_SCLK   = 3'd2,
    OP_SRST   = 3'd3,
    OP_SENSE  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EXEC,
    ST_SCLR,
    ST_SWAIT
  } st_e;

  localparam logic [7:0] RES_BAD = 8'hFF;
  localparam logic [7:0] RES_NIL = 8'h00;
endpackage

// File: rtl/dbg_sync.sv
`timescale 1ns/1ps
module dbg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbg_clk_sense.sv
`timescale 1ns/1ps
module dbg_clk_sense #(
  parameter int unsigned STAGES = 2
) (
  input  logic sys_clk,
  input  logic hclk,
  input  logic hrst_n,
  input  logic clr,
  output logic seen
);
  logic flag;

  // Flag lives in the system clock domain; clear comes from a host flop.
  always_ff @(posedge sys_clk or posedge clr) begin
    if (clr) flag <= 1'b0;
    else     flag <= 1'b1;
  end

  dbg_sync #(.WIDTH(1), .STAGES(STAGES)) u_sync (
    .clk   (hclk),
    .rst_n (hrst_n),
    .d     (flag),
    .q     (seen)
  );
endmodule

// File: rtl/dbg_rst_hold.sv
`timescale 1ns/1ps
module dbg_rst_hold #(
  parameter int unsigned HOLD_CYCLES = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic req
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(HOLD_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign req = (cnt != '0);

  // R3: the request only starts because a reset command was taken
  assert_req_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(load));

  // R4: a reload while holding never lets the request drop
  assert_req_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && load) |=> req);
endmodule

// File: rtl/dbg_cmd_unit.sv
`timescale 1ns/1ps
module dbg_cmd_unit
  import dbg_cmd_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 50_000_000,
  parameter int unsigned SENSE_WAIT  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       hclk,
  input  logic       hrst_n,
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       cmd_start,
  input  logic [2:0] cmd_code,
  input  logic [7:0] cmd_data,
  output logic       busy,
  output logic       done,
  output logic [7:0] result,
  output logic       reset_request
);
  localparam int unsigned WW = $clog2(SENSE_WAIT + 1);

  st_e           state;
  logic [2:0]    code_q;
  logic [7:0]    data_q;
  logic [WW-1:0] wait_cnt;
  logic          done_q;
  logic [7:0]    result_q;
  logic          clr_q;
  logic          accept;
  logic          hold_load;
  logic [1:0]    lvl_s;
  logic          seen_s;
  logic [7:0]    exec_res;

  assign accept    = cmd_start && (state == ST_IDLE);
  assign hold_load = accept && (cmd_code == OP_RSTSYS);

  dbg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk   (hclk),
    .rst_n (hrst_n),
    .d     ({sys_rst_n, sys_clk}),
    .q     (lvl_s)
  );

  dbg_clk_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .sys_clk (sys_clk),
    .hclk    (hclk),
    .hrst_n  (hrst_n),
    .clr     (clr_q),
    .seen    (seen_s)
  );

  dbg_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (hclk),
    .rst_n (hrst_n),
    .load  (hold_load),
    .req   (reset_request)
  );

  always_comb begin
    case (code_q)
      OP_LOOP:   exec_res = data_q;
      OP_RSTSYS: exec_res = RES_NIL;
      OP_SCLK:   exec_res = {7'b0, lvl_s[0]};
      OP_SRST:   exec_res = {7'b0, lvl_s[1]};
      default:   exec_res = RES_BAD;
    endcase
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      state    <= ST_IDLE;
      code_q   <= '0;
      data_q   <= '0;
      wait_cnt <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      clr_q    <= 1'b1;
    end else begin
      done_q <= 1'b0;
      clr_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            code_q <= cmd_code;
            data_q <= cmd_data;
            if (cmd_code == OP_SENSE) begin
              state <= ST_SCLR;
              clr_q <= 1'b1;
            end else begin
              state <= ST_EXEC;
            end
          end
        end
        ST_EXEC: begin
          result_q <= exec_res;
          done_q   <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_SCLR: begin
          wait_cnt <= WW'(SENSE_WAIT - 1);
          state    <= ST_SWAIT;
        end
        default: begin
          if (wait_cnt == '0) begin
            result_q <= {7'b0, seen_s};
            done_q   <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = result_q;

  // R10: completion strobe is a single cycle
  assert_done_pulse_R10: assert property (@(posedge hclk) disable iff (!hrst_n)
    done |=> !done);

  // R10: result moves only together with done
  assert_result_stable_R10: assert property (@(posedge hclk) disable iff (!hrst_n)
    !done |-> $stable(result));

  // R9: done always follows a busy period
  assert_done_after_busy_R9: assert property (@(posedge hclk) disable iff (!hrst_n)
    done |-> $past(busy));

  // R9: busy and done never overlap
  assert_busy_done_excl_R9: assert property (@(posedge hclk) disable iff (!hrst_n)
    !(busy && done));
endmodule

// File: tb/sim_dbg_cmd_unit.sv
`timescale 1ns/1ps
module sim_dbg_cmd_unit;
  localparam int HOLD = 20;
  localparam int SWAIT = 12;

  logic       hclk = 1'b0;
  logic       hrst_n = 1'b0;
  logic       sys_clk = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       cmd_start = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [7:0] cmd_data = '0;
  logic       busy, done, reset_request;
  logic [7:0] result;

  logic sys_run = 1'b0;
  logic sys_lvl = 1'b0;
  int   cyc = 0;
  int   hi_cnt = 0;
  int   nchk = 0;
  int   nfail = 0;
  int   acc_cyc = 0;

  dbg_cmd_unit #(.HOLD_CYCLES(HOLD), .SENSE_WAIT(SWAIT), .SYNC_STAGES(2)) u0 (
    .hclk(hclk), .hrst_n(hrst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .cmd_start(cmd_start), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .busy(busy), .done(done), .result(result), .reset_request(reset_request)
  );

  always #2 hclk = ~hclk;

  always begin
    #7;
    if (sys_run) sys_clk = ~sys_clk;
    else         sys_clk = sys_lvl;
  end

  always @(posedge hclk) cyc <= cyc + 1;
  always @(negedge hclk) if (reset_request) hi_cnt <= hi_cnt + 1;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic [7:0] data,
                       output logic [7:0] r, output int lat);
    @(negedge hclk);
    cmd_start = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge hclk);
    cmd_start = 1'b0;
    acc_cyc = cyc;
    chk(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
    lat = 0;
    while (!done && lat < 300) begin
      @(negedge hclk);
      lat++;
    end
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
    r = result;
    @(negedge hclk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    chk(result == r, "R10 result stable", int'(result), int'(r));
  endtask

  task automatic settle(input logic run, input logic lvl);
    sys_lvl = lvl;
    sys_run = run;
    repeat (12) @(negedge hclk);
  endtask

  initial begin
    logic [7:0] r;
    int lat, h0, a1, a2, extra;
    bit wd = 0;
    fork
      begin
        repeat (3) @(negedge hclk);
        // R1 reset state
        chk(busy == 0 && done == 0 && reset_request == 0 && result == 8'h00,
            "R1 reset state", int'({busy, done, reset_request}), 0);
        hrst_n = 1'b1;
        repeat (2) @(negedge hclk);
        chk(result == 8'h00 && reset_request == 0, "R1 after release", int'(result), 0);

        // R2 exhaustive loopback, R11 latency
        for (int v = 0; v < 256; v++) begin
          issue(3'd0, v[7:0], r, lat);
          chk(r == v[7:0], "R2 loopback", int'(r), v);
          chk(lat == 1, "R11 loopback latency", lat, 1);
        end

        // R8 unknown codes
        for (int c = 5; c < 8; c++) begin
          issue(c[2:0], 8'h3C, r, lat);
          chk(r == 8'hFF, "R8 unknown code", int'(r), 255);
          chk(lat == 1, "R11 unknown latency", lat, 1);
        end

        // R5 sample clock at both steady levels
        for (int l = 0; l < 2; l++) begin
          settle(1'b0, l[0]);
          issue(3'd2, 8'hAA, r, lat);
          chk(r == {7'b0, l[0]}, "R5 sample clock", int'(r), l);
          chk(lat == 1, "R11 sample clock latency", lat, 1);
        end

        // R6 sample reset at both levels
        for (int l = 0; l < 2; l++) begin
          sys_rst_n = l[0];
          repeat (4) @(negedge hclk);
          issue(3'd3, 8'h00, r, lat);
          chk(r == {7'b0, l[0]}, "R6 sample reset", int'(r), l);
          chk(lat == 1, "R11 sample reset latency", lat, 1);
        end
        sys_rst_n = 1'b1;

        // R7 sense: running, stopped low, stopped high after activity
        settle(1'b1, 1'b0);
        issue(3'd4, 8'h00, r, lat);
        chk(r == 8'h01, "R7 sense running", int'(r), 1);
        chk(lat >= SWAIT, "R7 sense wait length", lat, SWAIT);
        settle(1'b0, 1'b0);
        issue(3'd4, 8'h00, r, lat);
        chk(r == 8'h00, "R7 sense stopped low", int'(r), 0);
        settle(1'b1, 1'b0);
        settle(1'b0, 1'b1);
        issue(3'd4, 8'h00, r, lat);
        chk(r == 8'h00, "R7 sense stopped high after activity", int'(r), 0);

        // R9 starts during busy are ignored
        settle(1'b1, 1'b0);
        @(negedge hclk);
        cmd_start = 1'b1; cmd_code = 3'd4; cmd_data = 8'h00;
        @(negedge hclk);
        cmd_start = 1'b0;
        repeat (3) @(negedge hclk);
        chk(busy == 1'b1, "R9 still busy", int'(busy), 1);
        cmd_start = 1'b1; cmd_code = 3'd0; cmd_data = 8'h5A;
        @(negedge hclk);
        cmd_start = 1'b0; cmd_code = 3'd1;
        lat = 0;
        while (!done && lat < 300) begin
          @(negedge hclk);
          lat++;
        end
        chk(result == 8'h01, "R9 ignored start kept sense result", int'(result), 1);
        extra = 0;
        for (int k = 0; k < 10; k++) begin
          @(negedge hclk);
          if (done) extra++;
        end
        chk(extra == 0, "R9 no done for ignored start", extra, 0);
        chk(reset_request == 0, "R9 ignored start caused no reset", int'(reset_request), 0);

        // R3 hold length
        h0 = hi_cnt;
        issue(3'd1, 8'h00, r, lat);
        chk(r == 8'h00, "R3 reset result", int'(r), 0);
        chk(lat == 1, "R11 reset latency", lat, 1);
        repeat (HOLD + 10) @(negedge hclk);
        chk(hi_cnt - h0 == HOLD, "R3 hold cycles", hi_cnt - h0, HOLD);
        chk(reset_request == 0, "R3 released", int'(reset_request), 0);

        // R4 restart during hold
        h0 = hi_cnt;
        issue(3'd1, 8'h00, r, lat);
        a1 = acc_cyc;
        repeat (5) @(negedge hclk);
        issue(3'd1, 8'h00, r, lat);
        a2 = acc_cyc;
        repeat (HOLD + 10) @(negedge hclk);
        chk(hi_cnt - h0 == (a2 - a1) + HOLD, "R4 restart hold", hi_cnt - h0, (a2 - a1) + HOLD);
      end
      begin
        repeat (150000) @(negedge hclk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog expired", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule